// File: doc/BRIEF.md
# Programmable-Step Wrapping Up-Counter

This block is an up-counter whose step size, start value, wrap-reload value and upper limit are set at run time through a small write-only register port. The counter width and the signed or unsigned reading of the count are fixed at design time by parameters. On every accepted count tick the count grows by the programmed step. When the next value would pass the programmed limit, the counter reloads its wrap value instead and raises a terminal-count pulse.

A synchronous clear input forces the count to the wrap-reload value. A load strobe copies the start value into the count. The count is a single registered word, so it can be read coherently in any cycle. An advance strobe pulses once for every accepted tick, which lets downstream logic or an interrupt source follow the counter without polling it.

Top module: `stride_counter`

## Requirements
- R1: After the asynchronous reset `rst_ni` is low, `count_o` is 0, `adv_o` and `tc_o` are 0, and the settings take their defaults: reload 0, step 1, start 0, limit equal to the largest value of the count type (32767 for the default 16-bit signed build).
- R2: While `wr_en_i` is high, `wr_data_i` is written to the setting picked by `wr_sel_i`: 0 selects the reload value, 1 the step, 2 the start value and 3 the limit.
- R3: A tick (`tick_i` high, `clr_i` and `load_i` low) that does not wrap makes `count_o` equal to the old count plus the step, with the step read as unsigned, in the cycle after the tick edge.
- R4: When `load_i` is high and `clr_i` is low, the start value is copied into the count, and a tick in the same cycle is ignored.
- R5: When the old count plus the step is greater than the limit, the tick loads the reload value rather than the sum, and `tc_o` is high for exactly the following cycle.
- R6: `tc_o` is high only in a cycle in which `adv_o` is also high.
- R7: `adv_o` is high for exactly one cycle after each accepted tick and low in every other cycle, and the new count is visible in that same cycle.
- R8: When `clr_i` is high, the count takes the reload value whatever `load_i` and `tick_i` do.
- R9: In the default signed 16-bit build, with reload -32768, limit 32767 and step 1, the count goes through every value from -32768 to 32767 in order and then wraps back to -32768 with a terminal-count pulse. A step of 65535 taken from -32768 lands on 32767 without wrapping.
- R10: A setting written in the same cycle as a tick takes effect from the next tick. The tick in that cycle still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to the reload value |
| load_i | input | 1 | Copy the start value into the count |
| tick_i | input | 1 | Count enable for this cycle |
| wr_en_i | input | 1 | Setting write strobe |
| wr_sel_i | input | 2 | Setting select: 0 reload, 1 step, 2 start, 3 limit |
| wr_data_i | input | WIDTH | Setting write data |
| count_o | output | WIDTH | Current count |
| adv_o | output | 1 | One-cycle pulse after each accepted tick |
| tc_o | output | 1 | One-cycle pulse after a wrap |

## Verification
The assertions assume that `clr_i`, `load_i`, `tick_i` and the write port are steady around the rising edge, and that no setting changes between a tick and the check one cycle later unless the write happened in the tick cycle itself. The step and reload checks compare against settings sampled in the tick cycle, so this is what keeps them valid. The bench drives every input on the falling edge, one operation per cycle, and includes writes that share a cycle with a tick. It also drives clear, load and tick together to exercise the priority order.

// File: rtl/stride_counter_pkg.sv
package stride_counter_pkg;
  localparam int NUM_CFG = 4;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    CFG_RELOAD = 2'd0,
    CFG_STEP   = 2'd1,
    CFG_START  = 2'd2,
    CFG_LIMIT  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/stride_cfg_regs.sv
module stride_cfg_regs
  import stride_counter_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter bit SIGNED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] reload_o,
  output logic [WIDTH-1:0] step_o,
  output logic [WIDTH-1:0] start_o,
  output logic [WIDTH-1:0] limit_o
);
  // largest value of the count type
  localparam logic [WIDTH-1:0] LIMIT_RST = {WIDTH{1'b1}} >> SIGNED;

  function automatic logic [WIDTH-1:0] rst_val(int idx);
    case (idx)
      int'(CFG_STEP):  return WIDTH'(1);
      int'(CFG_LIMIT): return LIMIT_RST;
      default:         return '0;
    endcase
  endfunction

  logic [WIDTH-1:0] cfg_q [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g] <= rst_val(g);
      end else if (wr_en_i && (wr_sel_i == SEL_W'(g))) begin
        cfg_q[g] <= wr_data_i;
      end
    end
  end

  assign reload_o = cfg_q[CFG_RELOAD];
  assign step_o   = cfg_q[CFG_STEP];
  assign start_o  = cfg_q[CFG_START];
  assign limit_o  = cfg_q[CFG_LIMIT];
endmodule

// File: rtl/stride_step_calc.sv
module stride_step_calc #(
  parameter int WIDTH  = 16,
  parameter bit SIGNED = 1'b1
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic [WIDTH-1:0] step_i,
  input  logic [WIDTH-1:0] limit_i,
  input  logic [WIDTH-1:0] reload_i,
  output logic [WIDTH-1:0] next_o,
  output logic             wrap_o
);
  // two guard bits: sum never overflows, sign bit stays valid in both modes
  localparam int EXT_W = WIDTH + 2;

  logic [EXT_W-1:0] cnt_x, lim_x, step_x, sum_x;

  if (SIGNED) begin : g_sext
    assign cnt_x = {{2{count_i[WIDTH-1]}}, count_i};
    assign lim_x = {{2{limit_i[WIDTH-1]}}, limit_i};
  end else begin : g_zext
    assign cnt_x = {2'b00, count_i};
    assign lim_x = {2'b00, limit_i};
  end

  assign step_x = {2'b00, step_i};
  assign sum_x  = cnt_x + step_x;
  assign wrap_o = $signed(sum_x) > $signed(lim_x);
  assign next_o = wrap_o ? reload_i : sum_x[WIDTH-1:0];
endmodule

// File: rtl/stride_count_core.sv
module stride_count_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] reload_i,
  input  logic [WIDTH-1:0] start_i,
  input  logic [WIDTH-1:0] next_i,
  input  logic             wrap_i,
  output logic [WIDTH-1:0] count_o,
  output logic             adv_o,
  output logic             tc_o
);
  // priority: clear, then load, then tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      adv_o   <= 1'b0;
      tc_o    <= 1'b0;
    end else begin
      adv_o <= 1'b0;
      tc_o  <= 1'b0;
      if (clr_i) begin
        count_o <= reload_i;
      end else if (load_i) begin
        count_o <= start_i;
      end else if (tick_i) begin
        count_o <= next_i;
        adv_o   <= 1'b1;
        tc_o    <= wrap_i;
      end
    end
  end
endmodule

// File: rtl/stride_counter.sv
module stride_counter
  import stride_counter_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter bit SIGNED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             adv_o,
  output logic             tc_o
);
  logic [WIDTH-1:0] reload_w, step_w, start_w, limit_w, next_w;
  logic             wrap_w;

  stride_cfg_regs #(.WIDTH(WIDTH), .SIGNED(SIGNED)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .reload_o  (reload_w),
    .step_o    (step_w),
    .start_o   (start_w),
    .limit_o   (limit_w)
  );

  stride_step_calc #(.WIDTH(WIDTH), .SIGNED(SIGNED)) u_calc (
    .count_i  (count_o),
    .step_i   (step_w),
    .limit_i  (limit_w),
    .reload_i (reload_w),
    .next_o   (next_w),
    .wrap_o   (wrap_w)
  );

  stride_count_core #(.WIDTH(WIDTH)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .load_i   (load_i),
    .tick_i   (tick_i),
    .reload_i (reload_w),
    .start_i  (start_w),
    .next_i   (next_w),
    .wrap_i   (wrap_w),
    .count_o  (count_o),
    .adv_o    (adv_o),
    .tc_o     (tc_o)
  );
endmodule

// File: rtl/stride_counter_chk.sv
module stride_counter_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             load_i,
  input logic             tick_i,
  input logic [WIDTH-1:0] count_o,
  input logic             adv_o,
  input logic             tc_o,
  input logic [WIDTH-1:0] reload_q,
  input logic [WIDTH-1:0] start_q,
  input logic [WIDTH-1:0] step_q
);
  AST_CLR_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == $past(reload_q)); // R8

  AST_LOAD_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i) |=> count_o == $past(start_q)); // R4

  AST_STEP_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && !tc_o) |-> count_o == $past(count_o) + $past(step_q)); // R3

  AST_WRAP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> count_o == $past(reload_q)); // R5

  AST_TC_WITH_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> adv_o); // R6

  AST_ADV_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && !load_i) |=> adv_o); // R7

  AST_ADV_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && !clr_i && !load_i) |=> !adv_o); // R7
endmodule

bind stride_counter stride_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .load_i   (load_i),
  .tick_i   (tick_i),
  .count_o  (count_o),
  .adv_o    (adv_o),
  .tc_o     (tc_o),
  .reload_q (reload_w),
  .start_q  (start_w),
  .step_q   (step_w)
);

// File: tb/stride_counter_tb.sv
module stride_counter_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr_i = 1'b0, load_i = 1'b0, tick_i = 1'b0, wr_en_i = 1'b0;
  logic [1:0]   wr_sel_i = '0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] count_o;
  logic         adv_o, tc_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  stride_counter #(.WIDTH(W), .SIGNED(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr_i), .load_i(load_i), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .count_o(count_o), .adv_o(adv_o), .tc_o(tc_o)
  );

  // reference model state
  longint m_cnt = 0, m_rel = 0, m_step = 1, m_start = 0, m_lim = 32767;

  logic [W+1:0] q_exp[$];
  string        q_tag[$];

  function automatic longint sx(logic [W-1:0] v);
    return longint'($signed(v));
  endfunction

  task automatic check(string tag, logic [W+1:0] act, logic [W+1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual count=%0h adv=%0b tc=%0b expected count=%0h adv=%0b tc=%0b",
               tag, act[W+1:2], act[1], act[0], exp[W+1:2], exp[1], exp[0]);
    end
  endtask

  // driver: one operation per cycle, expected result queued after the edge
  task automatic drive(bit clr, bit ld, bit tk, bit we, logic [1:0] a,
                       logic [W-1:0] d, string tag);
    logic st, tc;
    longint sum;
    @(negedge clk);
    clr_i = clr; load_i = ld; tick_i = tk;
    wr_en_i = we; wr_sel_i = a; wr_data_i = d;
    st = 1'b0; tc = 1'b0;
    if (clr) m_cnt = m_rel;
    else if (ld) m_cnt = m_start;
    else if (tk) begin
      sum = m_cnt + m_step;
      st = 1'b1;
      if (sum > m_lim) begin m_cnt = m_rel; tc = 1'b1; end
      else m_cnt = sum;
    end
    if (we) begin
      case (a)
        2'd0: m_rel = sx(d);
        2'd1: m_step = longint'(d);
        2'd2: m_start = sx(d);
        default: m_lim = sx(d);
      endcase
    end
    @(posedge clk);
    #1;
    q_exp.push_back({W'(m_cnt), st, tc});
    q_tag.push_back(tag);
  endtask

  task automatic tick(string tag);
    drive(0, 0, 1, 0, 2'd0, '0, tag);
  endtask
  task automatic idle(string tag);
    drive(0, 0, 0, 0, 2'd0, '0, tag);
  endtask
  task automatic wr(logic [1:0] a, logic [W-1:0] d, string tag);
    drive(0, 0, 0, 1, a, d, tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [W+1:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, {count_o, adv_o, tc_o}, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {count_o, adv_o, tc_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {count_o, adv_o, tc_o}, '0);

    idle("R7 idle no pulse");
    tick("R1 default step");
    tick("R3 step 1");
    drive(0, 0, 1, 1, 2'd1, 16'd5, "R10 write with tick");
    tick("R10 new step");
    idle("R7 gap");
    tick("R3 step 5");

    // default limit and reload
    wr(2'd1, 16'd1, "R2 step write");
    wr(2'd2, 16'd32766, "R2 start write");
    drive(0, 1, 0, 0, 2'd0, '0, "R4 load");
    tick("R3 to max");
    tick("R5 default limit wrap");
    tick("R5 after wrap");

    wr(2'd1, 16'd5, "R2 step 5");
    wr(2'd2, 16'd100, "R2 start 100");
    drive(0, 1, 0, 0, 2'd0, '0, "R4 load 100");
    drive(0, 1, 1, 0, 2'd0, '0, "R4 load beats tick");
    wr(2'd3, 16'd112, "R2 limit 112");
    for (int i = 0; i < 4; i++) tick("R5 wrap at 112");
    wr(2'd0, 16'hFFEC, "R2 reload -20");
    drive(1, 0, 0, 0, 2'd0, '0, "R8 clear");
    tick("R3 from -20");
    drive(1, 1, 1, 0, 2'd0, '0, "R8 clear beats load and tick");
    for (int i = 0; i < 30; i++) begin
      tick("R5 signed run");
      if (i % 3 == 0) idle("R7 gap");
    end

    // full signed range
    wr(2'd0, 16'h8000, "R9 reload min");
    wr(2'd3, 16'h7FFF, "R9 limit max");
    wr(2'd1, 16'd1, "R9 step 1");
    drive(1, 0, 0, 0, 2'd0, '0, "R9 clear to min");
    for (int i = 0; i < 65536; i++) tick("R9 full range");

    wr(2'd1, 16'd0, "R2 step 0");
    tick("R3 step 0 holds");
    wr(2'd1, 16'hFFFF, "R9 step 65535");
    tick("R9 big step lands on max");
    tick("R9 big step wraps");
    idle("R7 final idle");

    wait (q_exp.size() == 0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule